// File: doc/BRIEF.md
# Single-Cycle Ten-Instruction Processor Core

This block is a 32-bit processor core that finishes one instruction every clock cycle. It supports ten instructions from the base RISC-V integer encoding. Within a single cycle it does all of the following: it takes the instruction word from a combinational fetch port, decodes it, reads two source registers, and uses either the adder/comparator or the multiplier. It may also touch a combinational data port before it writes the result back. The logic is divided into a control table, an immediate builder, a register file with two read ports, and a CSR-mapped I/O unit. The top level wires these together with the PC, the ALU and the multiplier.

The core exchanges data with the rest of the system in three ways:
- Three 32-bit input words, which it reads with CSR read instructions.
- Three 32-bit output registers, which it loads with CSR write instructions.
- A trace port, which reports the PC and the writeback value of every instruction as it completes.

Neither memory port has a ready signal, and neither applies back-pressure. A request is valid for the cycle in which it is driven, and the memory must return its answer combinationally in that same cycle.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high, `fetch_val`, `dmem_val` and `trc_val` are low. The output registers are cleared to zero at the clock edge. In the first cycle after `rst` falls, the fetch address is 0x00000000.
- R2: Outside reset, `fetch_val` and `trc_val` are high in every cycle, and `fetch_addr` and `trc_pc` both equal the PC.
- R3: Any instruction that does not transfer control moves the PC forward by 4 at the next edge. A word that is not one of the ten instructions (for example 0x00000000) writes nothing, makes no data request, and only moves the PC forward.
- R4: The following arithmetic results appear on `trc_wdata` in the same cycle:
  - ADDI (opcode 0010011, funct3 000) writes rs1 plus the sign-extended I immediate.
  - ADD (opcode 0110011, funct3 000, funct7 0000000) writes rs1+rs2.
  - MUL (the same encoding with funct7 0000001) writes the low 32 bits of rs1*rs2.
- R5: LW (opcode 0000011, funct3 010) drives a read (`dmem_wr`=0) at rs1 plus the I immediate and writes the returned word. SW (opcode 0100011, funct3 010) drives a write (`dmem_wr`=1) at rs1 plus the S immediate, with rs2 on `dmem_wdata`.
- R6: JAL (opcode 1101111) moves the PC to PC plus the J immediate and writes PC+4.
- R7: JR, encoded as jalr x0, rs1, 0 (opcode 1100111, funct3 000), moves the PC to the value of rs1.
- R8: BNE (opcode 1100011, funct3 001) moves the PC to PC plus the B immediate when rs1 differs from rs2. Otherwise the PC moves to PC+4.
- R9: CSR read, encoded as csrrs rd, csr, x0 (opcode 1110011, funct3 010), writes `io_in` slice i when the CSR number is 0xFC0+i for i from 0 to 2. It writes zero for any other CSR number.
- R10: CSR write, encoded as csrrw x0, csr, rs1 (opcode 1110011, funct3 001), loads rs1 into `io_out` slice i when the CSR number is 0x7C0+i. No other slice changes.
- R11: Register x0 always reads as zero, and writes to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_val | output | 1 | Instruction fetch request valid |
| fetch_addr | output | 32 | Instruction fetch address (the PC) |
| fetch_data | input | 32 | Instruction word, returned in the same cycle |
| dmem_val | output | 1 | Data request valid |
| dmem_wr | output | 1 | Request type: 0 read, 1 write |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data, returned in the same cycle |
| io_in | input | 96 | Three input words; slice i is bits [32i+31:32i] |
| io_out | output | 96 | Three output registers, laid out in the same slices |
| trc_val | output | 1 | An instruction completes this cycle |
| trc_pc | output | 32 | PC of the completing instruction |
| trc_wdata | output | 32 | Register writeback value; undefined when nothing is written |

## Verification
The hardest behaviours to observe from the ports are the ones that leave no trace in the trace port:
- a write aimed at x0, whose trace value is undefined by rule;
- a word the core does not recognise;
- a branch that is not taken.

The program exposes each of these through a later instruction. After the write to x0, an ADD reads x0 back, and the trace must show zero. Fill words are placed at every skipped address, so any fall-through past a jump or a taken branch changes the sequence of trace PCs. The unrecognised word must be followed by the very next address, with no data request in its cycle.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  typedef enum logic [1:0] {PC_PLUS4 = 2'd0, PC_REL = 2'd1, PC_REG = 2'd2} pc_sel_e;
  typedef enum logic [1:0] {IMM_I = 2'd0, IMM_S = 2'd1, IMM_J = 2'd2, IMM_B = 2'd3} imm_sel_e;
  typedef enum logic [2:0] {WB_ALU = 3'd0, WB_MUL = 3'd1, WB_LOAD = 3'd2,
                            WB_LINK = 3'd3, WB_CSR = 3'd4} wb_sel_e;
  typedef enum logic [1:0] {XF_NONE = 2'd0, XF_JAL = 2'd1, XF_REG = 2'd2, XF_BNE = 2'd3} xfer_e;

  typedef struct packed {
    imm_sel_e imm_sel;
    logic     op2_imm;
    logic     alu_eq;
    wb_sel_e  wb_sel;
    logic     rf_wen;
    logic     fetch;
    logic     mem_val;
    logic     mem_wr;
    logic     csr_wr;
  } ctrl_t;

endpackage

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            wen,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr_a,
  output logic [XLEN-1:0] rdata_a,
  input  logic [AW-1:0]   raddr_b,
  output logic [XLEN-1:0] rdata_b
);
  logic [XLEN-1:0] regs [NREGS];

  // Index 0 is never written, so reads of it are forced to zero below.
  always_ff @(posedge clk) begin
    if (wen && waddr != '0) regs[waddr] <= wdata;
  end

  // Reads see the registered value only, so a same-cycle write is not visible yet.
  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/sc_imm_gen.sv
module sc_imm_gen #(
  parameter int XLEN = 32
) (
  input  logic [31:7]          inst,
  input  sc_core_pkg::imm_sel_e sel,
  output logic [XLEN-1:0]      imm
);
  import sc_core_pkg::*;
  localparam int EXT = XLEN - 32;

  logic [31:0] imm32;

  always_comb begin
    case (sel)
      IMM_I:   imm32 = {{20{inst[31]}}, inst[31:20]};
      IMM_S:   imm32 = {{20{inst[31]}}, inst[31:25], inst[11:7]};
      IMM_J:   imm32 = {{12{inst[31]}}, inst[19:12], inst[20], inst[30:21], 1'b0};
      default: imm32 = {{20{inst[31]}}, inst[7], inst[30:25], inst[11:8], 1'b0};
    endcase
  end

  generate
    if (EXT > 0) begin : g_wide
      assign imm = {{EXT{imm32[31]}}, imm32};
    end else begin : g_exact
      assign imm = imm32;
    end
  endgenerate
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl (
  input  logic                 rst,
  input  logic [6:0]           opcode,
  input  logic [2:0]           funct3,
  input  logic [6:0]           funct7,
  input  logic                 eq,
  output sc_core_pkg::ctrl_t   c,
  output sc_core_pkg::pc_sel_e pc_sel
);
  import sc_core_pkg::*;

  xfer_e xfer;

  // One row per instruction; anything unmatched keeps the all-zero row (no-op).
  always_comb begin
    c    = '0;
    xfer = XF_NONE;
    if (!rst) begin
      c.fetch = 1'b1;
      case (opcode)
        OPC_IMM: if (funct3 == 3'b000) begin
          c.imm_sel = IMM_I; c.op2_imm = 1'b1; c.wb_sel = WB_ALU; c.rf_wen = 1'b1;
        end
        OPC_REG: if (funct3 == 3'b000) begin
          if (funct7 == 7'b0000000) begin
            c.wb_sel = WB_ALU; c.rf_wen = 1'b1;
          end else if (funct7 == 7'b0000001) begin
            c.wb_sel = WB_MUL; c.rf_wen = 1'b1;
          end
        end
        OPC_LOAD: if (funct3 == 3'b010) begin
          c.imm_sel = IMM_I; c.op2_imm = 1'b1; c.mem_val = 1'b1;
          c.wb_sel = WB_LOAD; c.rf_wen = 1'b1;
        end
        OPC_STORE: if (funct3 == 3'b010) begin
          c.imm_sel = IMM_S; c.op2_imm = 1'b1; c.mem_val = 1'b1; c.mem_wr = 1'b1;
        end
        OPC_JAL: begin
          c.imm_sel = IMM_J; c.wb_sel = WB_LINK; c.rf_wen = 1'b1; xfer = XF_JAL;
        end
        OPC_JALR: if (funct3 == 3'b000) xfer = XF_REG;
        OPC_BRANCH: if (funct3 == 3'b001) begin
          c.imm_sel = IMM_B; c.alu_eq = 1'b1; xfer = XF_BNE;
        end
        OPC_SYSTEM: begin
          if (funct3 == 3'b010) begin
            c.wb_sel = WB_CSR; c.rf_wen = 1'b1;
          end else if (funct3 == 3'b001) begin
            c.csr_wr = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // The next-PC choice is kept apart so the branch outcome never feeds the operand selects.
  always_comb begin
    case (xfer)
      XF_JAL:  pc_sel = PC_REL;
      XF_REG:  pc_sel = PC_REG;
      XF_BNE:  pc_sel = eq ? PC_PLUS4 : PC_REL;
      default: pc_sel = PC_PLUS4;
    endcase
  end
endmodule

// File: rtl/sc_csr_io.sv
module sc_csr_io #(
  parameter int          XLEN         = 32,
  parameter int          IO_N         = 3,
  parameter logic [11:0] CSR_IN_BASE  = 12'hFC0,
  parameter logic [11:0] CSR_OUT_BASE = 12'h7C0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [11:0]          csr_num,
  input  logic                 wr_en,
  input  logic [XLEN-1:0]      wdata,
  input  logic [IO_N*XLEN-1:0] io_in,
  output logic [XLEN-1:0]      rd_val,
  output logic [IO_N*XLEN-1:0] io_out
);
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < IO_N; i++) begin
      if (csr_num == CSR_IN_BASE + 12'(i)) rd_val = io_in[i*XLEN +: XLEN];
    end
  end

  generate
    for (genvar g = 0; g < IO_N; g++) begin : g_out
      logic [XLEN-1:0] oreg;
      always_ff @(posedge clk) begin
        if (rst) oreg <= '0;
        else if (wr_en && csr_num == CSR_OUT_BASE + 12'(g)) oreg <= wdata;
      end
      assign io_out[g*XLEN +: XLEN] = oreg;
    end
  endgenerate
endmodule

// File: rtl/sc_core.sv
module sc_core #(
  parameter int          XLEN         = 32,
  parameter int          NREGS        = 32,
  parameter int          IO_N         = 3,
  parameter logic [11:0] CSR_IN_BASE  = 12'hFC0,
  parameter logic [11:0] CSR_OUT_BASE = 12'h7C0
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic                 fetch_val,
  output logic [XLEN-1:0]      fetch_addr,
  input  logic [31:0]          fetch_data,
  output logic                 dmem_val,
  output logic                 dmem_wr,
  output logic [XLEN-1:0]      dmem_addr,
  output logic [XLEN-1:0]      dmem_wdata,
  input  logic [XLEN-1:0]      dmem_rdata,
  input  logic [IO_N*XLEN-1:0] io_in,
  output logic [IO_N*XLEN-1:0] io_out,
  output logic                 trc_val,
  output logic [XLEN-1:0]      trc_pc,
  output logic [XLEN-1:0]      trc_wdata
);
  import sc_core_pkg::*;
  localparam int AW = $clog2(NREGS);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  ctrl_t           c;
  pc_sel_e         pc_sel;
  logic [XLEN-1:0] pc, pc_next, pc_plus4, pc_target;
  logic [XLEN-1:0] rs1_val, rs2_val, imm, op2, sum, alu_res, prod, csr_val, wb_val;
  logic            eq;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  sc_ctrl u_ctrl (
    .rst(rst), .opcode(fetch_data[6:0]), .funct3(fetch_data[14:12]),
    .funct7(fetch_data[31:25]), .eq(eq), .c(c), .pc_sel(pc_sel)
  );

  sc_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk(clk), .wen(c.rf_wen), .waddr(fetch_data[7 +: AW]), .wdata(wb_val),
    .raddr_a(fetch_data[15 +: AW]), .rdata_a(rs1_val),
    .raddr_b(fetch_data[20 +: AW]), .rdata_b(rs2_val)
  );

  sc_imm_gen #(.XLEN(XLEN)) u_imm (
    .inst(fetch_data[31:7]), .sel(c.imm_sel), .imm(imm)
  );

  sc_csr_io #(.XLEN(XLEN), .IO_N(IO_N), .CSR_IN_BASE(CSR_IN_BASE),
              .CSR_OUT_BASE(CSR_OUT_BASE)) u_csr (
    .clk(clk), .rst(rst), .csr_num(fetch_data[31:20]), .wr_en(c.csr_wr),
    .wdata(rs1_val), .io_in(io_in), .rd_val(csr_val), .io_out(io_out)
  );

  // Execute: one shared adder for arithmetic and addresses, a comparator for BNE.
  assign op2     = c.op2_imm ? imm : rs2_val;
  assign sum     = rs1_val + op2;
  assign eq      = (rs1_val == op2);
  assign alu_res = c.alu_eq ? {{(XLEN-1){1'b0}}, eq} : sum;
  assign prod    = rs1_val * rs2_val;

  assign pc_plus4  = pc + STEP;
  assign pc_target = pc + imm;

  always_comb begin
    case (pc_sel)
      PC_REL:  pc_next = pc_target;
      PC_REG:  pc_next = rs1_val;
      default: pc_next = pc_plus4;
    endcase
  end

  always_comb begin
    case (c.wb_sel)
      WB_MUL:  wb_val = prod;
      WB_LOAD: wb_val = dmem_rdata;
      WB_LINK: wb_val = pc_plus4;
      WB_CSR:  wb_val = csr_val;
      default: wb_val = alu_res;
    endcase
  end

  assign fetch_val  = c.fetch;
  assign fetch_addr = pc;
  assign dmem_val   = c.mem_val;
  assign dmem_wr    = c.mem_wr;
  assign dmem_addr  = sum;
  assign dmem_wdata = rs2_val;
  assign trc_val    = c.fetch;
  assign trc_pc     = pc;
  assign trc_wdata  = wb_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_val,
  input logic [XLEN-1:0] fetch_addr,
  input logic [31:0]     fetch_data,
  input logic            dmem_val,
  input logic            dmem_wr,
  input logic            trc_val,
  input logic [XLEN-1:0] trc_pc,
  input logic [XLEN-1:0] trc_wdata
);
  logic [6:0]      opc;
  logic [2:0]      f3;
  logic            is_lw, is_sw, is_jal, is_xfer, has_rd;
  logic [XLEN-1:0] jimm;

  assign opc     = fetch_data[6:0];
  assign f3      = fetch_data[14:12];
  assign has_rd  = fetch_data[11:7] != 5'd0;
  assign is_lw   = opc == 7'b0000011 && f3 == 3'b010;
  assign is_sw   = opc == 7'b0100011 && f3 == 3'b010;
  assign is_jal  = opc == 7'b1101111;
  assign is_xfer = is_jal || opc == 7'b1100111 || opc == 7'b1100011;
  assign jimm    = XLEN'($signed({fetch_data[31], fetch_data[19:12], fetch_data[20],
                                  fetch_data[30:21], 1'b0}));

  // R1: nothing is requested or traced during reset
  always @(negedge clk) begin
    if (rst) a_r1_quiet_in_reset: assert (!fetch_val && !dmem_val && !trc_val);
  end

  a_r1_start_at_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> fetch_addr == '0);

  a_r2_fetch_and_trace: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> fetch_val && trc_val && trc_pc == fetch_addr);

  a_r3_sequential_pc: assert property (@(posedge clk) disable iff (rst)
    !is_xfer |=> fetch_addr == $past(fetch_addr) + XLEN'(4));

  a_r5_store_request: assert property (@(posedge clk) disable iff (rst)
    is_sw |-> dmem_val && dmem_wr);

  a_r5_load_request: assert property (@(posedge clk) disable iff (rst)
    is_lw |-> dmem_val && !dmem_wr);

  a_r5_no_stray_request: assert property (@(posedge clk) disable iff (rst)
    !is_lw && !is_sw |-> !dmem_val);

  a_r6_jal_link: assert property (@(posedge clk) disable iff (rst)
    is_jal && has_rd |-> trc_wdata == trc_pc + XLEN'(4));

  a_r6_jal_target: assert property (@(posedge clk) disable iff (rst)
    is_jal |=> fetch_addr == $past(fetch_addr) + $past(jimm));
endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .fetch_val(fetch_val), .fetch_addr(fetch_addr),
  .fetch_data(fetch_data), .dmem_val(dmem_val), .dmem_wr(dmem_wr),
  .trc_val(trc_val), .trc_pc(trc_pc), .trc_wdata(trc_wdata)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam logic [31:0] IN0 = 32'hA5A5_0001;
  localparam logic [31:0] IN1 = 32'h1234_5678;
  localparam logic [31:0] IN2 = 32'h0BAD_F00D;
  localparam int N = 25;

  // {pc, writeback, compare writeback, requirement number}
  localparam logic [68:0] TBL [N] = '{
    {32'h00, 32'd5,          1'b1, 4'd4},  // R4 addi x1,x0,5
    {32'h04, 32'd2,          1'b1, 4'd4},  // R4 addi x2,x1,-3
    {32'h08, 32'd7,          1'b1, 4'd4},  // R4 add x3,x1,x2
    {32'h0c, 32'd35,         1'b1, 4'd4},  // R4 mul x4,x3,x1
    {32'h10, 32'h40,         1'b1, 4'd4},  // R4 addi x5,x0,0x40
    {32'h14, 32'd0,          1'b0, 4'd5},  // R5 sw x4,8(x5)
    {32'h18, 32'd35,         1'b1, 4'd5},  // R5 lw x6,8(x5)
    {32'h1c, 32'h20,         1'b1, 4'd6},  // R6 jal x7,+12
    {32'h28, IN1,            1'b1, 4'd9},  // R9 csr read slot 1
    {32'h2c, 32'd0,          1'b0, 4'd10}, // R10 csr write slot 2
    {32'h30, 32'd0,          1'b0, 4'd8},  // R8 bne taken
    {32'h3c, 32'd0,          1'b0, 4'd8},  // R8 bne not taken
    {32'h40, 32'h50,         1'b1, 4'd4},  // R4 addi x9,x0,0x50
    {32'h44, 32'd0,          1'b0, 4'd7},  // R7 jr x9
    {32'h50, 32'd35,         1'b1, 4'd11}, // R11 add x10,x4,x0
    {32'h54, 32'd0,          1'b0, 4'd11}, // R11 addi x0,x0,7
    {32'h58, 32'd0,          1'b1, 4'd11}, // R11 add x11,x0,x0
    {32'h5c, 32'd0,          1'b1, 4'd9},  // R9 unlisted csr reads zero
    {32'h60, IN0,            1'b1, 4'd9},  // R9 csr read slot 0
    {32'h64, 32'd6,          1'b1, 4'd4},  // R4 addi x1,x1,1
    {32'h68, 32'hFFFF_FFFF,  1'b1, 4'd4},  // R4 addi x14,x0,-1
    {32'h6c, 32'd1,          1'b1, 4'd4},  // R4 mul x15,x14,x14
    {32'h70, 32'd0,          1'b0, 4'd3},  // R3 unrecognised word
    {32'h74, 32'd0,          1'b0, 4'd3},  // R3 jal x0,self
    {32'h74, 32'd0,          1'b0, 4'd6}   // R6 self loop repeats
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_val, dmem_val, dmem_wr, trc_val;
  logic [31:0] fetch_addr, fetch_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic [31:0] trc_pc, trc_wdata;
  logic [95:0] io_in, io_out;
  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  assign io_in      = {IN2, IN1, IN0};
  assign fetch_data = imem[fetch_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_val && dmem_wr) dmem[dmem_addr[7:2]] <= dmem_wdata;

  sc_core u_sc_core (
    .clk(clk), .rst(rst), .fetch_val(fetch_val), .fetch_addr(fetch_addr),
    .fetch_data(fetch_data), .dmem_val(dmem_val), .dmem_wr(dmem_wr),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .io_in(io_in), .io_out(io_out), .trc_val(trc_val), .trc_pc(trc_pc),
    .trc_wdata(trc_wdata)
  );

  function automatic logic [31:0] e_i(int imm, int rs1, int f3, int rd, logic [6:0] op);
    logic [31:0] v = 32'(imm);
    return {v[11:0], 5'(rs1), 3'(f3), 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_r(int f7, int rs2, int rs1, int rd);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_s(int imm, int rs2, int rs1);
    logic [31:0] v = 32'(imm);
    return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_j(int off, int rd);
    logic [31:0] v = 32'(off);
    return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
  endfunction
  function automatic logic [31:0] e_b(int off, int rs2, int rs1);
    logic [31:0] v = 32'(off);
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'b001, v[4:1], v[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_csrr(int csr, int rd);
    return {12'(csr), 5'd0, 3'b010, 5'(rd), 7'b1110011};
  endfunction
  function automatic logic [31:0] e_csrw(int csr, int rs1);
    return {12'(csr), 5'(rs1), 3'b001, 5'd0, 7'b1110011};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] fill;
    fill = e_i(99, 0, 0, 1, 7'b0010011);
    for (int k = 0; k < 64; k++) begin imem[k] = fill; dmem[k] = '0; end
    imem[0]  = e_i(5, 0, 0, 1, 7'b0010011);
    imem[1]  = e_i(-3, 1, 0, 2, 7'b0010011);
    imem[2]  = e_r(0, 2, 1, 3);
    imem[3]  = e_r(1, 1, 3, 4);
    imem[4]  = e_i(64, 0, 0, 5, 7'b0010011);
    imem[5]  = e_s(8, 4, 5);
    imem[6]  = e_i(8, 5, 2, 6, 7'b0000011);
    imem[7]  = e_j(12, 7);
    imem[10] = e_csrr(12'hFC1, 8);
    imem[11] = e_csrw(12'h7C2, 8);
    imem[12] = e_b(12, 2, 1);
    imem[15] = e_b(-60, 1, 1);
    imem[16] = e_i(80, 0, 0, 9, 7'b0010011);
    imem[17] = {12'd0, 5'd9, 3'b000, 5'd0, 7'b1100111};
    imem[20] = e_r(0, 0, 4, 10);
    imem[21] = e_i(7, 0, 0, 0, 7'b0010011);
    imem[22] = e_r(0, 0, 0, 11);
    imem[23] = e_csrr(12'h123, 12);
    imem[24] = e_csrr(12'hFC0, 13);
    imem[25] = e_i(1, 1, 0, 1, 7'b0010011);
    imem[26] = e_i(-1, 0, 0, 14, 7'b0010011);
    imem[27] = e_r(1, 14, 14, 15);
    imem[28] = 32'h0000_0000;
    imem[29] = e_j(0, 0);

    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 fetch_val in reset", 32'(fetch_val), 0);
    chk("R1 trc_val in reset", 32'(trc_val), 0);
    chk("R1 dmem_val in reset", 32'(dmem_val), 0);
    chk("R1 io_out cleared", io_out[31:0] | io_out[63:32] | io_out[95:64], 0);

    rst = 1'b0;
    #1;
    for (int i = 0; i < N; i++) begin
      logic [68:0] row;
      string       tag;
      if (i > 0) begin @(negedge clk); #1; end
      row = TBL[i];
      tag = $sformatf("R%0d row %0d", row[3:0], i);
      chk({tag, " pc"}, trc_pc, row[68:37]);
      chk("R2 fetch matches trace", fetch_addr, trc_pc);
      chk("R2 valids high", {30'd0, fetch_val, trc_val}, 32'd3);
      if (row[4]) chk({tag, " wdata"}, trc_wdata, row[36:5]);
      if (i == 5) begin
        chk("R5 store type", {30'd0, dmem_val, dmem_wr}, 32'd3);
        chk("R5 store addr", dmem_addr, 32'h48);
        chk("R5 store data", dmem_wdata, 32'd35);
      end
      if (i == 6) chk("R5 load type", {30'd0, dmem_val, dmem_wr}, 32'd2);
      if (i == 22) chk("R3 no request on unknown word", 32'(dmem_val), 0);
    end

    chk("R5 memory holds stored word", dmem[18], 32'd35);
    chk("R10 slot 2 loaded", io_out[95:64], IN1);
    chk("R10 slot 0 untouched", io_out[31:0], 0);
    chk("R10 slot 1 untouched", io_out[63:32], 0);

    // R1: reset in mid-run, then restart from address zero
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R1 fetch drops in reset", 32'(fetch_val), 0);
    @(negedge clk);
    chk("R1 outputs cleared by reset", io_out[95:64], 0);
    rst = 1'b0;
    #1;
    chk("R1 restart pc", fetch_addr, 0);
    chk("R1 restart first result", trc_wdata, 32'd5);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule